// File: doc/BRIEF.md
# Byte and Halfword Swap Unit

This unit rearranges the bytes of a 32-bit operand in one of three ways: it swaps the two bytes inside each halfword, reverses the order of all four bytes, or exchanges the upper and lower halfwords. The enclosing core writes back the result and four condition flags: zero, sign, carry and overflow. Carry is not an arithmetic carry here. It reports a zero byte or a zero halfword in the result, and the rule depends on the operation. Overflow is always cleared.

Operands arrive on a valid/ready stream. The result and its flags leave one cycle later through a single output register, which also carries a valid/ready handshake. A beat is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output register holds its contents and no new operand is taken. A new operand can be accepted in every cycle while the consumer keeps `out_ready` high.

Top module: `swap_unit`

## Requirements
- R1: With `in_op` = 2'b00 (pair swap), result bits 31:24 come from operand bits 23:16, bits 23:16 from 31:24, bits 15:8 from 7:0, and bits 7:0 from 15:8.
- R2: With `in_op` = 2'b01 (full reversal), result byte 0 is operand byte 3, byte 1 is byte 2, byte 2 is byte 1, and byte 3 is byte 0.
- R3: With `in_op` = 2'b10 (halfword exchange), result bits 31:16 are operand bits 15:0 and result bits 15:0 are operand bits 31:16.
- R4: With `in_op` = 2'b11, the result is 0, all four flags are 0 and `out_flags_we` is 0. The three other codes drive `out_flags_we` to 1.
- R5: For every swap, `out_zero` is 1 exactly when the result is 0, and `out_sign` equals result bit 31.
- R6: `out_overflow` is 0 for every operation.
- R7: For the pair swap, `out_carry` is 1 when result bits 15:8 or result bits 7:0 are zero.
- R8: For the full reversal, `out_carry` is 1 when any of the four result bytes is zero.
- R9: For the halfword exchange, `out_carry` is 1 when result bits 31:16 or result bits 15:0 are zero.
- R10: A beat accepted at a clock edge shows its result and flags, with `out_valid` high, after that edge. With `out_ready` held high, one beat is accepted per cycle.
- R11: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and the result, the flags and `out_valid` hold steady.
- R12: During and after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand beat is present |
| in_ready | output | 1 | Unit can take a beat this cycle |
| in_operand | input | 32 | Source operand |
| in_op | input | 2 | Operation: 00 pair swap, 01 reversal, 10 halfword exchange, 11 none |
| out_valid | output | 1 | Result register holds a beat |
| out_ready | input | 1 | Consumer takes the beat this cycle |
| out_result | output | 32 | Swapped value |
| out_zero | output | 1 | Result is zero |
| out_sign | output | 1 | Result bit 31 |
| out_carry | output | 1 | Zero-byte or zero-halfword indication |
| out_overflow | output | 1 | Always 0 |
| out_flags_we | output | 1 | Flags should be written back |

## Verification
The vectors target the places where the carry rules differ between operations. A pair swap whose only zero byte lies in the upper halfword must leave carry clear. A halfword exchange of 0x00FF00FF has zero bytes but no zero halfword, so carry must also stay clear. A design that used one shared zero-byte test for all three operations would set carry in both cases. Operands with bit 31 set after the swap, but not before it, expose a sign flag taken from the operand instead of the result. Code 11 checks that an unused operation writes no flags. A stall test holds `out_ready` low while a second operand waits. A stage that overwrote its register or kept `in_ready` high would lose the first beat or change it.

// File: rtl/swap_pkg.sv
package swap_pkg;

  typedef enum logic [1:0] {
    SW_PAIR = 2'b00,
    SW_REV  = 2'b01,
    SW_HALF = 2'b10,
    SW_NONE = 2'b11
  } swap_op_e;

  typedef struct packed {
    logic zero;
    logic sign;
    logic carry;
    logic ovf;
  } swap_flags_t;

endpackage

// File: rtl/swap_lanes.sv
module swap_lanes
  import swap_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 4
) (
  input  logic [BYTE_W*NUM_BYTES-1:0] operand,
  input  swap_op_e                    op,
  output logic [BYTE_W*NUM_BYTES-1:0] result
);
  localparam int DATA_W = BYTE_W * NUM_BYTES;
  localparam int HALF_B = NUM_BYTES / 2;

  logic [DATA_W-1:0] pair_v, rev_v, half_v;

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
    localparam int PAIR_SRC = i ^ 1;
    localparam int REV_SRC  = NUM_BYTES - 1 - i;
    localparam int HALF_SRC = (i + HALF_B) % NUM_BYTES;
    assign pair_v[i*BYTE_W +: BYTE_W] = operand[PAIR_SRC*BYTE_W +: BYTE_W];
    assign rev_v [i*BYTE_W +: BYTE_W] = operand[REV_SRC*BYTE_W  +: BYTE_W];
    assign half_v[i*BYTE_W +: BYTE_W] = operand[HALF_SRC*BYTE_W +: BYTE_W];
  end

  always_comb begin
    unique case (op)
      SW_PAIR: result = pair_v;
      SW_REV:  result = rev_v;
      SW_HALF: result = half_v;
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/swap_flags.sv
module swap_flags
  import swap_pkg::*;
#(
  parameter int BYTE_W       = 8,
  parameter int NUM_BYTES    = 4,
  parameter bit BORROW_TRICK = 1'b1
) (
  input  logic [BYTE_W*NUM_BYTES-1:0] result,
  input  swap_op_e                    op,
  output swap_flags_t                 flags,
  output logic                        flags_we
);
  localparam int DATA_W = BYTE_W * NUM_BYTES;
  localparam int HALF_B = NUM_BYTES / 2;
  localparam logic [DATA_W-1:0] LSB_EACH = {NUM_BYTES{{{(BYTE_W-1){1'b0}}, 1'b1}}};
  localparam logic [DATA_W-1:0] MSB_EACH = {NUM_BYTES{{1'b1, {(BYTE_W-1){1'b0}}}}};

  logic [NUM_BYTES-1:0] byte_zero;
  logic                 any_byte_zero;
  logic                 pair_c, half_c;

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_bz
    assign byte_zero[i] = (result[i*BYTE_W +: BYTE_W] == '0);
  end

  if (BORROW_TRICK) begin : g_borrow
    logic [DATA_W-1:0] dec;
    assign dec           = result - LSB_EACH;
    assign any_byte_zero = |(dec & ~result & MSB_EACH);
  end else begin : g_reduce
    assign any_byte_zero = |byte_zero;
  end

  assign pair_c = byte_zero[0] | byte_zero[1];
  assign half_c = (&byte_zero[HALF_B-1:0]) | (&byte_zero[NUM_BYTES-1:HALF_B]);

  always_comb begin
    flags    = '0;
    flags_we = 1'b0;
    if (op != SW_NONE) begin
      flags_we   = 1'b1;
      flags.zero = (result == '0);
      flags.sign = result[DATA_W-1];
      unique case (op)
        SW_PAIR: flags.carry = pair_c;
        SW_REV:  flags.carry = any_byte_zero;
        SW_HALF: flags.carry = half_c;
        default: flags.carry = 1'b0;
      endcase
      flags.ovf = 1'b0;
    end
  end

endmodule

// File: rtl/swap_out_stage.sv
module swap_out_stage
  import swap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_result,
  input  swap_flags_t       in_flags,
  input  logic              in_flags_we,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output swap_flags_t       out_flags,
  output logic              out_flags_we
);
  logic              valid_q;
  logic [DATA_W-1:0] result_q;
  swap_flags_t       flags_q;
  logic              we_q;

  assign in_ready = !valid_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      flags_q  <= '0;
      we_q     <= 1'b0;
    end else if (in_ready) begin
      valid_q <= in_valid;
      if (in_valid) begin
        result_q <= in_result;
        flags_q  <= in_flags;
        we_q     <= in_flags_we;
      end
    end
  end

  assign out_valid    = valid_q;
  assign out_result   = result_q;
  assign out_flags    = flags_q;
  assign out_flags_we = we_q;

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !out_ready) |=> (valid_q && $stable(result_q) && $stable(flags_q) && $stable(we_q)));

  // R10
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> valid_q);

endmodule

// File: rtl/swap_unit.sv
module swap_unit
  import swap_pkg::*;
#(
  parameter int BYTE_W       = 8,
  parameter int NUM_BYTES    = 4,
  parameter bit BORROW_TRICK = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [BYTE_W*NUM_BYTES-1:0] in_operand,
  input  logic [1:0]                  in_op,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [BYTE_W*NUM_BYTES-1:0] out_result,
  output logic                        out_zero,
  output logic                        out_sign,
  output logic                        out_carry,
  output logic                        out_overflow,
  output logic                        out_flags_we
);
  localparam int DATA_W = BYTE_W * NUM_BYTES;
  localparam int HALF_W = DATA_W / 2;

  swap_op_e          op_e;
  logic [DATA_W-1:0] swapped;
  swap_flags_t       flags_c, flags_q;
  logic              we_c;

  assign op_e = swap_op_e'(in_op);

  swap_lanes #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_lanes (
    .operand (in_operand),
    .op      (op_e),
    .result  (swapped)
  );

  swap_flags #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .BORROW_TRICK(BORROW_TRICK)) u_flags (
    .result   (swapped),
    .op       (op_e),
    .flags    (flags_c),
    .flags_we (we_c)
  );

  swap_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_result    (swapped),
    .in_flags     (flags_c),
    .in_flags_we  (we_c),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_result   (out_result),
    .out_flags    (flags_q),
    .out_flags_we (out_flags_we)
  );

  assign out_zero     = flags_q.zero;
  assign out_sign     = flags_q.sign;
  assign out_carry    = flags_q.carry;
  assign out_overflow = flags_q.ovf;

  // R3
  half_exchange_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 2'b10) |=>
      (out_result == {$past(in_operand[HALF_W-1:0]), $past(in_operand[DATA_W-1:HALF_W])}));

  // R4
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_flags_we) |-> (out_result == '0 && !out_zero && !out_sign && !out_carry));

  // R5
  zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags_we) |-> (out_zero == (out_result == '0) && out_sign == out_result[DATA_W-1]));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_overflow);

  // R12
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && in_ready));

endmodule

// File: tb/tb_swap_unit.sv
`timescale 1ns/1ps
module tb_swap_unit;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] din;
    logic [31:0] dout;
    logic [4:0]  fl;   // {zero, sign, carry, overflow, flags_we}
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 32'h12345678, 32'h34127856, 5'b00001},  // R1 R7
    '{2'b00, 32'h00FF0000, 32'hFF000000, 5'b01101},  // R1 R7 sign
    '{2'b00, 32'hAB00CD12, 32'h00AB12CD, 5'b00001},  // R7 upper zero byte ignored
    '{2'b00, 32'h00000000, 32'h00000000, 5'b10101},  // R5 zero
    '{2'b00, 32'h0000FF00, 32'h000000FF, 5'b00101},  // R7
    '{2'b01, 32'h12345678, 32'h78563412, 5'b00001},  // R2 R8
    '{2'b01, 32'h11223300, 32'h00332211, 5'b00101},  // R8
    '{2'b01, 32'h80FFFF01, 32'h01FFFF80, 5'b00001},  // R5 sign from result
    '{2'b01, 32'h000000F0, 32'hF0000000, 5'b01101},  // R8
    '{2'b01, 32'h01010101, 32'h01010101, 5'b00001},  // R8 no false carry
    '{2'b10, 32'h12345678, 32'h56781234, 5'b00001},  // R3 R9
    '{2'b10, 32'h0000ABCD, 32'hABCD0000, 5'b01101},  // R9
    '{2'b10, 32'h00FF00FF, 32'h00FF00FF, 5'b00001},  // R9 zero bytes, no zero half
    '{2'b10, 32'hFFFF8001, 32'h8001FFFF, 5'b01001},  // R9
    '{2'b11, 32'h12345678, 32'h00000000, 5'b00000},  // R4
    '{2'b11, 32'hFFFFFFFF, 32'h00000000, 5'b00000}   // R4
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_operand = '0;
  logic [1:0]  in_op = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_zero, out_sign, out_carry, out_overflow, out_flags_we;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  swap_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_op(in_op), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_zero(out_zero),
    .out_sign(out_sign), .out_carry(out_carry), .out_overflow(out_overflow),
    .out_flags_we(out_flags_we)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(logic [1:0] op);
    case (op)
      2'b00:   return "R1 R5 R6 R7";
      2'b01:   return "R2 R5 R6 R8";
      2'b10:   return "R3 R5 R6 R9";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [4:0] flags_now();
    return {out_zero, out_sign, out_carry, out_overflow, out_flags_we};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    check("R12 out_valid in reset", {63'd0, out_valid}, 64'd0);
    check("R12 in_ready in reset", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 out_valid after reset", {63'd0, out_valid}, 64'd0);

    // Vector table, one beat at a time
    for (int k = 0; k < NV; k++) begin
      in_valid   = 1'b1;
      in_op      = VECS[k].op;
      in_operand = VECS[k].din;
      @(negedge clk);
      in_valid = 1'b0;
      check({req_of(VECS[k].op), " R10 valid"}, {63'd0, out_valid}, 64'd1);
      check({req_of(VECS[k].op), " result"}, {32'd0, out_result}, {32'd0, VECS[k].dout});
      check({req_of(VECS[k].op), " flags"}, {59'd0, flags_now()}, {59'd0, VECS[k].fl});
    end

    // R10: back-to-back beats, one per cycle
    @(negedge clk);
    in_valid = 1'b1; in_op = 2'b01; in_operand = 32'hA1B2C3D4;
    @(negedge clk);
    check("R10 beat1", {32'd0, out_result}, {32'd0, 32'hD4C3B2A1});
    check("R10 ready while streaming", {63'd0, in_ready}, 64'd1);
    in_op = 2'b10; in_operand = 32'hA1B2C3D4;
    @(negedge clk);
    check("R10 beat2", {32'd0, out_result}, {32'd0, 32'hC3D4A1B2});
    in_op = 2'b00; in_operand = 32'hA1B2C3D4;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 beat3", {32'd0, out_result}, {32'd0, 32'hB2A1D4C3});
    @(negedge clk);
    check("R10 valid drops when idle", {63'd0, out_valid}, 64'd0);

    // R11: back-pressure
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 2'b01; in_operand = 32'h12345678;
    @(negedge clk);
    in_op = 2'b10; in_operand = 32'h0000ABCD;
    check("R11 in_ready low when stalled", {63'd0, in_ready}, 64'd0);
    check("R11 first beat", {32'd0, out_result}, {32'd0, 32'h78563412});
    repeat (2) @(negedge clk);
    check("R11 result held", {32'd0, out_result}, {32'd0, 32'h78563412});
    check("R11 valid held", {63'd0, out_valid}, 64'd1);
    check("R11 flags held", {59'd0, flags_now()}, {59'd0, 5'b00001});
    check("R11 in_ready still low", {63'd0, in_ready}, 64'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 waiting beat delivered", {32'd0, out_result}, {32'd0, 32'hABCD0000});
    check("R11 waiting beat flags", {59'd0, flags_now()}, {59'd0, 5'b01101});
    @(negedge clk);
    check("R11 drained", {63'd0, out_valid}, 64'd0);

    // R12: reset while holding a beat
    in_valid = 1'b1; in_op = 2'b00; in_operand = 32'h11111111;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R12 async reset clears valid", {63'd0, out_valid}, 64'd0);
    check("R12 in_ready after reset", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule